// File: doc/BRIEF.md
# SDRAM Command Controller

This block sits between a simple host port and a single-data-rate SDRAM with four banks, 4096 rows and 512 columns of 32-bit words. Each host transfer moves one word. The controller opens the addressed row, then issues a column read or write that closes the row by itself when the access ends. It also runs the power-up sequence and inserts periodic auto-refresh between accesses.

The host presents a request with a direction, a word address and, for writes, a data word. It holds the request until the controller signals that it will take it. Read data returns later as a one-cycle valid pulse. Every device pin is driven from a register. The CAS latency (2 or 3) and the refresh interval (normal or high-temperature grade) are set by parameters. All minimum command spacings are counted in clocks.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is low, the command pins show NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), `sd_dq_oe_o` is low and `ready_o` is low.
- R2: Power-up follows a fixed order, and no ACTIVE may be issued before it ends. After at least INIT_CYC clocks, the controller issues PRECHARGE with A10 high, then two AUTO REFRESH commands, then LOAD MODE. LOAD MODE carries BA = 0 and an A word whose CAS latency sits in A6:A4, with burst type A3 = 0 (sequential), burst length A2:A0 = 000 (one word) and all other bits zero.
- R3: Commands use these `{cs_n,ras_n,cas_n,we_n}` codes: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000, NOP 0111. No other code appears.
- R4: The host address splits into bank = addr[22:21], row = addr[20:9] and column = addr[8:0]. ACTIVE drives the bank on BA and the row on A. The READ or WRITE that follows goes to the same bank. It drives the column on A8:A0, sets A10 = 1 (auto-precharge) and clears A9 and A11.
- R5: Each command is followed by a minimum number of clocks before the next non-NOP command. These are T_RP after PRECHARGE, T_RFC after AUTO REFRESH, T_MRD after LOAD MODE, T_RCD after ACTIVE, T_WR+T_RP after WRITE and CAS_LAT+T_RP after READ.
- R6: `sd_dq_oe_o` is high exactly in the cycles where WRITE is on the pins. In those cycles `sd_dq_o` carries the accepted write word.
- R7: After READ appears on the pins, `rvalid_o` pulses for exactly one cycle, CAS_LAT+1 cycles later. `rdata_o` then holds `sd_dq_i` as sampled at the end of the CAS_LAT-th cycle after READ.
- R8: A refresh request is raised every REFI clocks. When the host is idle, AUTO REFRESH commands are therefore exactly REFI clocks apart. A pending refresh is served before any new host request, so under continuous traffic no refresh gap exceeds REFI plus one access.
- R9: A transfer is accepted on a rising edge where `req_i` and `ready_o` are both high. `ready_o` is low in the cycle after acceptance.
- R10: With HOT_GRADE = 1, the refresh interval is REFI_HOT_CYC instead of REFI_NORM_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 23 | Word address {bank,row,column} |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Request taken on this edge when high |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank select |
| sd_a_o | output | 12 | Row / column / mode address |
| sd_dq_o | output | 32 | Data toward the device |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | 32 | Data from the device |

## Verification
Two controllers run side by side against a behavioural device model: one with CAS latency 3 and the normal refresh grade, the other with latency 2 and the hot grade. The directed accesses cover the all-zero and all-ones addresses, words that differ only in bank, row or column, all-zero and all-ones data, and words preloaded straight into the model. Only a correct field split returns such a word, and a fixed read latency separates a wrong capture stage from a right one. A long stream of alternating writes and reads keeps refresh waiting behind host traffic, while idle stretches expose the exact refresh period of each grade.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IREF,
    ST_LMR,
    ST_IDLE,
    ST_ACCESS
  } ctrl_state_e;

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  localparam int ADDR_W = BA_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BA_W-1:0]   bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);

  assign bank_o = addr_i[ADDR_W-1 -: BA_W];
  assign row_o  = addr_i[COL_W +: ROW_W];
  assign col_o  = addr_i[COL_W-1:0];

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REFI = 3900,
  localparam int CW = $clog2(REFI + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(REFI - 1);
      pend_q <= 1'b0;
    end else begin
      if (cnt_q == '0) begin
        cnt_q  <= CW'(REFI - 1);
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CW'(1);
        if (ack_i) pend_q <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  // R8
  ref_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(cnt_q == '0));

  // R8
  ref_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && cnt_q != '0) |=> !pend_q);

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int CAS_LAT = 3,
  parameter int DW      = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,   // READ is on the pins this cycle
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  logic [CAS_LAT-1:0] sr_q;
  logic               cap;

  assign cap = sr_q[CAS_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      sr_q     <= {sr_q[CAS_LAT-2:0], issue_i};
      rvalid_o <= cap;
      if (cap) rdata_o <= dq_i;
    end
  end

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int BA_W          = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int DW            = 32,
  parameter int CAS_LAT       = 3,
  parameter int INIT_CYC      = 25000,
  parameter int T_RP          = 5,
  parameter int T_RCD         = 5,
  parameter int T_RFC         = 16,
  parameter int T_MRD         = 2,
  parameter int T_WR          = 2,
  parameter int REFI_NORM_CYC = 3900,
  parameter int REFI_HOT_CYC  = 975,
  parameter bit HOT_GRADE     = 1'b0,
  localparam int ADDR_W = BA_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ready_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              sd_cs_no,
  output logic              sd_ras_no,
  output logic              sd_cas_no,
  output logic              sd_we_no,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic [ROW_W-1:0]  sd_a_o,
  output logic [DW-1:0]     sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DW-1:0]     sd_dq_i
);

  localparam int AP_BIT  = 10;
  localparam int REFI    = HOT_GRADE ? REFI_HOT_CYC : REFI_NORM_CYC;
  localparam int TMR_MAX = INIT_CYC + T_RFC + T_WR + T_RP + CAS_LAT + T_RCD + T_MRD;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4); // BL1, sequential

  ctrl_state_e      state_q;
  sd_cmd_e          cmd_q;
  logic [TW-1:0]    tmr_q;
  logic             tmr_zero;
  logic             iref_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] a_q;
  logic [DW-1:0]    dq_q;
  logic             oe_q;
  logic             we_q;
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    wd_q;
  logic [BA_W-1:0]  req_bank;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [ROW_W-1:0] a_rw;
  logic             ref_pend;
  logic             ref_ack;
  logic             accept;

  sdram_addr_split #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr_i (addr_i),
    .bank_o (req_bank),
    .row_o  (req_row),
    .col_o  (req_col)
  );

  sdram_ref_timer #(.REFI(REFI)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  sdram_rd_pipe #(.CAS_LAT(CAS_LAT), .DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (cmd_q == CMD_RD),
    .dq_i     (sd_dq_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign tmr_zero = (tmr_q == '0);
  assign ref_ack  = (state_q == ST_IDLE) && tmr_zero && ref_pend;
  assign ready_o  = (state_q == ST_IDLE) && tmr_zero && !ref_pend;
  assign accept   = ready_o && req_i;

  always_comb begin
    a_rw              = '0;
    a_rw[COL_W-1:0]   = col_q;
    a_rw[AP_BIT]      = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      tmr_q   <= TW'(INIT_CYC);
      cmd_q   <= CMD_NOP;
      iref_q  <= 1'b0;
      ba_q    <= '0;
      a_q     <= '0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      col_q   <= '0;
      wd_q    <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      if (!tmr_zero) tmr_q <= tmr_q - TW'(1);
      unique case (state_q)
        ST_PWRUP: if (tmr_zero) begin
          cmd_q     <= CMD_PRE;
          a_q       <= '0;
          a_q[AP_BIT] <= 1'b1;
          tmr_q     <= TW'(T_RP - 1);
          state_q   <= ST_IREF;
        end
        ST_IREF: if (tmr_zero) begin
          cmd_q  <= CMD_REF;
          tmr_q  <= TW'(T_RFC - 1);
          iref_q <= 1'b1;
          if (iref_q) state_q <= ST_LMR;
        end
        ST_LMR: if (tmr_zero) begin
          cmd_q   <= CMD_LMR;
          ba_q    <= '0;
          a_q     <= MODE_WORD;
          tmr_q   <= TW'(T_MRD - 1);
          state_q <= ST_IDLE;
        end
        ST_IDLE: if (tmr_zero) begin
          if (ref_pend) begin
            cmd_q <= CMD_REF;
            tmr_q <= TW'(T_RFC - 1);
          end else if (req_i) begin
            cmd_q   <= CMD_ACT;
            ba_q    <= req_bank;
            a_q     <= req_row;
            col_q   <= req_col;
            we_q    <= we_i;
            wd_q    <= wdata_i;
            tmr_q   <= TW'(T_RCD - 1);
            state_q <= ST_ACCESS;
          end
        end
        ST_ACCESS: if (tmr_zero) begin
          a_q     <= a_rw;
          state_q <= ST_IDLE;
          if (we_q) begin
            cmd_q <= CMD_WR;
            dq_q  <= wd_q;
            oe_q  <= 1'b1;
            tmr_q <= TW'(T_WR + T_RP - 1);
          end else begin
            cmd_q <= CMD_RD;
            tmr_q <= TW'(CAS_LAT + T_RP - 1);
          end
        end
        default: state_q <= ST_PWRUP;
      endcase
    end
  end

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd_q;
  assign sd_ba_o    = ba_q;
  assign sd_a_o     = a_q;
  assign sd_dq_o    = dq_q;
  assign sd_dq_oe_o = oe_q;

  // ---- assertion-side tracking ----
  logic [TW-1:0]   since_act_q;
  logic [BA_W-1:0] act_ba_q;
  logic            mode_set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= '1;
      act_ba_q    <= '0;
      mode_set_q  <= 1'b0;
    end else begin
      if (cmd_q == CMD_ACT) begin
        since_act_q <= TW'(1);
        act_ba_q    <= sd_ba_o;
      end else if (since_act_q != '1) begin
        since_act_q <= since_act_q + TW'(1);
      end
      if (cmd_q == CMD_LMR) mode_set_q <= 1'b1;
    end
  end

  // R2
  act_after_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_ACT) |-> mode_set_q);

  // R5
  rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_act_q >= TW'(T_RCD)));

  // R4
  rw_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (sd_ba_o == act_ba_q));

  // R6
  oe_only_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_dq_oe_o |-> (cmd_q == CMD_WR));

  // R6
  wr_has_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_WR) |-> sd_dq_oe_o);

  // R7
  rvalid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(cmd_q == CMD_RD, CAS_LAT + 1));

  // R8
  ref_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && tmr_zero && ref_pend) |=> (cmd_q == CMD_REF));

  // R9
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

endmodule

// File: tb/sdram_ctrl_bench.sv
module sdram_bench_dev #(
  parameter int CL       = 3,
  parameter int INIT_CYC = 40,
  parameter int T_RP     = 3,
  parameter int T_RCD    = 3,
  parameter int T_RFC    = 7,
  parameter int T_MRD    = 2,
  parameter int T_WR     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic [11:0] a,
  input  logic [31:0] dq_o,
  input  logic        dq_oe,
  output logic [31:0] dq_i
);

  logic [31:0] mem [logic [22:0]];
  logic [11:0] open_row [4];
  bit          row_open [4];
  int cyc, busy_until, init_step, rd_wait;
  int ref_n, ref_last, ref_prev, max_gap;
  int n_chk, n_bad;
  logic [31:0] pend_data;
  logic [3:0]  cmd;

  function automatic logic [31:0] peek(input logic [22:0] k);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  task automatic poke(input logic [22:0] k, input logic [31:0] d);
    mem[k] = d;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s dev(CL=%0d) cyc=%0d actual=%0h expected=%0h", tag, CL, cyc, act, exp);
    end
  endtask

  initial begin
    dq_i = 32'hDEAD_BEEF;
    n_chk = 0; n_bad = 0; ref_n = 0; max_gap = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; busy_until = 0; init_step = 0; rd_wait = 0;
      ref_last = 0; ref_prev = 0;
      for (int b = 0; b < 4; b++) row_open[b] = 0;
    end else begin
      cyc++;
      cmd = {cs_n, ras_n, cas_n, we_n};
      if (rd_wait > 1) rd_wait--;
      else if (rd_wait == 1) begin dq_i <= pend_data; rd_wait = 0; end
      else dq_i <= 32'hDEAD_BEEF;
      if (cmd != 4'b0100 && dq_oe) chk(0, "R6 oe outside write", dq_oe, 0);
      if (cmd != 4'b0111) begin
        chk(cmd inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101}, "R3 command code", cmd, 4'b0111);
        chk(cyc >= busy_until, "R5 command spacing", cyc, busy_until);
        case (cmd)
          4'b0010: begin
            chk(init_step == 0 && a[10] && cyc > INIT_CYC, "R2 precharge-all", cyc, INIT_CYC);
            init_step = 1;
            busy_until = cyc + T_RP;
          end
          4'b0001: begin
            if (init_step == 1 || init_step == 2) init_step++;
            else begin
              chk(init_step == 4, "R2 refresh order", init_step, 4);
              ref_n++;
              if (ref_n >= 2 && cyc - ref_last > max_gap) max_gap = cyc - ref_last;
              ref_prev = ref_last;
              ref_last = cyc;
            end
            busy_until = cyc + T_RFC;
          end
          4'b0000: begin
            chk(init_step == 3, "R2 load mode order", init_step, 3);
            chk(a == 12'(CL << 4) && ba == 2'b00, "R2 mode word", {ba, a}, CL << 4);
            init_step = 4;
            busy_until = cyc + T_MRD;
          end
          4'b0011: begin
            chk(init_step == 4, "R2 active before init", init_step, 4);
            open_row[ba] = a;
            row_open[ba] = 1;
            busy_until = cyc + T_RCD;
          end
          4'b0100, 4'b0101: begin
            chk(row_open[ba] && a[10] && !a[11] && !a[9], "R4 column command", {row_open[ba], a}, 12'h400);
            row_open[ba] = 0;
            if (cmd == 4'b0100) begin
              chk(dq_oe, "R6 write oe", dq_oe, 1);
              mem[{ba, open_row[ba], a[8:0]}] = dq_o;
              busy_until = cyc + T_WR + T_RP;
            end else begin
              pend_data = peek({ba, open_row[ba], a[8:0]});
              rd_wait = CL - 1;
              busy_until = cyc + CL + T_RP;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module sdram_ctrl_bench;

  localparam int INIT_CYC = 40;
  localparam int T_RP = 3, T_RCD = 3, T_RFC = 7, T_MRD = 2, T_WR = 2;
  localparam int REFI_N = 400, REFI_H = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req [2];
  logic        we [2];
  logic [22:0] addr [2];
  logic [31:0] wdata [2];
  wire         ready [2];
  wire [31:0]  rdata [2];
  wire         rvalid [2];
  wire         cs_n [2], ras_n [2], cas_n [2], we_n [2], dq_oe [2];
  wire [1:0]   ba [2];
  wire [11:0]  a [2];
  wire [31:0]  dq_o [2];
  wire [31:0]  dq_i [2];

  int total = 0, bad = 0;
  bit done = 0;

  sdram_ctrl #(.CAS_LAT(3), .INIT_CYC(INIT_CYC), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_WR(T_WR), .REFI_NORM_CYC(REFI_N), .REFI_HOT_CYC(REFI_H), .HOT_GRADE(1'b0))
  u_sdram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .we_i(we[0]), .addr_i(addr[0]), .wdata_i(wdata[0]),
    .ready_o(ready[0]), .rdata_o(rdata[0]), .rvalid_o(rvalid[0]),
    .sd_cs_no(cs_n[0]), .sd_ras_no(ras_n[0]), .sd_cas_no(cas_n[0]), .sd_we_no(we_n[0]),
    .sd_ba_o(ba[0]), .sd_a_o(a[0]), .sd_dq_o(dq_o[0]), .sd_dq_oe_o(dq_oe[0]), .sd_dq_i(dq_i[0]));

  sdram_ctrl #(.CAS_LAT(2), .INIT_CYC(INIT_CYC), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_WR(T_WR), .REFI_NORM_CYC(REFI_N), .REFI_HOT_CYC(REFI_H), .HOT_GRADE(1'b1))
  u_sdram_ctrl_hot (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .we_i(we[1]), .addr_i(addr[1]), .wdata_i(wdata[1]),
    .ready_o(ready[1]), .rdata_o(rdata[1]), .rvalid_o(rvalid[1]),
    .sd_cs_no(cs_n[1]), .sd_ras_no(ras_n[1]), .sd_cas_no(cas_n[1]), .sd_we_no(we_n[1]),
    .sd_ba_o(ba[1]), .sd_a_o(a[1]), .sd_dq_o(dq_o[1]), .sd_dq_oe_o(dq_oe[1]), .sd_dq_i(dq_i[1]));

  sdram_bench_dev #(.CL(3), .INIT_CYC(INIT_CYC), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_WR(T_WR)) u_dev (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]), .we_n(we_n[0]),
    .ba(ba[0]), .a(a[0]), .dq_o(dq_o[0]), .dq_oe(dq_oe[0]), .dq_i(dq_i[0]));

  sdram_bench_dev #(.CL(2), .INIT_CYC(INIT_CYC), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_WR(T_WR)) u_dev_hot (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]), .we_n(we_n[1]),
    .ba(ba[1]), .a(a[1]), .dq_o(dq_o[1]), .dq_oe(dq_oe[1]), .dq_i(dq_i[1]));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] peek(input int s, input logic [22:0] k);
    return (s == 0) ? u_dev.peek(k) : u_dev_hot.peek(k);
  endfunction

  task automatic host_xfer(input int s, input bit w, input logic [22:0] ad, input logic [31:0] d,
                           output logic [31:0] rd, output int lat);
    @(negedge clk);
    req[s] = 1'b1; we[s] = w; addr[s] = ad; wdata[s] = d;
    while (!ready[s]) @(negedge clk);
    @(negedge clk);
    req[s] = 1'b0;
    lat = 1;
    check(!ready[s], "R9 ready low after accept", ready[s], 0);
    rd = '0;
    if (w) begin
      while (!ready[s]) @(negedge clk);
    end else begin
      while (!rvalid[s]) begin @(negedge clk); lat++; end
      rd = rdata[s];
      @(negedge clk);
      check(!rvalid[s], "R7 single valid pulse", rvalid[s], 0);
    end
  endtask

  task automatic t_write(input int s, input logic [22:0] ad, input logic [31:0] d);
    logic [31:0] rd; int lat;
    host_xfer(s, 1'b1, ad, d, rd, lat);
    check(peek(s, ad) == d, "R6 R4 word stored at split address", peek(s, ad), d);
  endtask

  task automatic t_read(input int s, input logic [22:0] ad, input logic [31:0] exp);
    logic [31:0] rd; int lat;
    int cl = (s == 0) ? 3 : 2;
    host_xfer(s, 1'b0, ad, 32'h0, rd, lat);
    check(rd == exp, "R7 R4 read data", rd, exp);
    check(lat == T_RCD + cl + 2, "R7 read latency", lat, T_RCD + cl + 2);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      for (int s = 0; s < 2; s++) begin
        check({cs_n[s], ras_n[s], cas_n[s], we_n[s]} == 4'b0111, "R1 NOP in reset",
              {cs_n[s], ras_n[s], cas_n[s], we_n[s]}, 4'b0111);
        check(!dq_oe[s] && !ready[s], "R1 oe and ready low in reset", {dq_oe[s], ready[s]}, 0);
      end
    end
  endtask

  task automatic t_init();
    for (int s = 0; s < 2; s++) begin
      while (!ready[s]) @(negedge clk);
      check(((s == 0) ? u_dev.init_step : u_dev_hot.init_step) == 4, "R2 init done before ready",
            (s == 0) ? u_dev.init_step : u_dev_hot.init_step, 4);
    end
  endtask

  task automatic t_split();
    t_write(0, 23'h000000, 32'h0000_0000);
    t_write(0, 23'h7FFFFF, 32'hFFFF_FFFF);
    t_write(0, 23'h200000, 32'h1111_0001);   // bank 1 only
    t_write(0, 23'h000200, 32'h2222_0002);   // row 1 only
    t_write(0, 23'h000001, 32'h3333_0003);   // column 1 only
    t_read(0, 23'h7FFFFF, 32'hFFFF_FFFF);
    t_read(0, 23'h200000, 32'h1111_0001);
    t_read(0, 23'h000200, 32'h2222_0002);
    t_read(0, 23'h000001, 32'h3333_0003);
    t_read(0, 23'h000000, 32'h0000_0000);
    u_dev.poke(23'h5A5A5A, 32'hA5A5_5A5A);
    t_read(0, 23'h5A5A5A, 32'hA5A5_5A5A);
    u_dev_hot.poke(23'h3FF1FF, 32'hC0DE_0042);
    t_read(1, 23'h3FF1FF, 32'hC0DE_0042);
    t_write(1, 23'h600155, 32'h8000_0001);
    t_read(1, 23'h600155, 32'h8000_0001);
  endtask

  task automatic t_stream();
    int n0 = u_dev.ref_n;
    for (int i = 0; i < 70; i++) begin
      logic [22:0] ad = {i[1:0], 12'(i * 37), 9'(i * 11)};
      logic [31:0] d = (i * 32'h0101_0101) ^ 32'h5A5A_0000;
      t_write(0, ad, d);
      t_read(0, ad, d);
    end
    check(u_dev.ref_n >= n0 + 3, "R8 refreshes during traffic", u_dev.ref_n, n0 + 3);
    check(u_dev.max_gap <= REFI_N + 16, "R8 refresh gap bound under traffic", u_dev.max_gap, REFI_N + 16);
  endtask

  task automatic t_idle_ref(input int s, input int refi, input string tag);
    int n0 = (s == 0) ? u_dev.ref_n : u_dev_hot.ref_n;
    while (((s == 0) ? u_dev.ref_n : u_dev_hot.ref_n) < n0 + 3) @(negedge clk);
    if (s == 0) check(u_dev.ref_last - u_dev.ref_prev == refi, tag, u_dev.ref_last - u_dev.ref_prev, refi);
    else check(u_dev_hot.ref_last - u_dev_hot.ref_prev == refi, tag,
               u_dev_hot.ref_last - u_dev_hot.ref_prev, refi);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      total += u_dev.n_chk + u_dev_hot.n_chk;
      bad   += u_dev.n_bad + u_dev_hot.n_bad;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      req[s] = 0; we[s] = 0; addr[s] = '0; wdata[s] = '0;
    end
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_init();
    t_split();
    t_idle_ref(0, REFI_N, "R8 idle refresh period");
    t_idle_ref(1, REFI_H, "R10 hot-grade refresh period");
    t_stream();
    repeat (10) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule